// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading translation words from memory. A walk starts from a context table whose location comes from a root pointer input and whose slot is picked by the current context number. From there it follows table pointers through up to three levels of page tables. It stops as soon as it finds a leaf entry, so a single walk maps a 16 MB, 256 KB or 4 KB page.

Each memory word carries its entry kind in its two lowest bits. A leaf entry also holds a page number, a permission code, a referenced flag and a modified flag. When a leaf is found, the walker may write the entry back with its status flags updated. It then reports the result with a one-cycle completion pulse: the physical address, the leaf level, the final entry and its permission code, or else a fault code with the level at which the walk stopped. Memory is reached through a single-word request port that uses a valid/ready handshake and allows one read in flight. A read returns its data on a response strobe. A write is complete once its request is accepted.

Only one walk runs at a time. The block takes a new request only while it is idle.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `done` are 0.
- R2: The first read of every walk goes to address (`root_ptr` << 4) + (`ctx_num` << 2).
- R3: The entry kind is word[1:0], with 0 = invalid, 1 = table pointer, 2 = leaf and 3 = reserved. A table pointer fetched at level L (0 to 2) leads to a read of level L+1 at ({word[31:2], 2'b00} << 4) + index*4. The index is va[31:24] for level 1, va[23:18] for level 2 and va[17:12] for level 3.
- R4: A leaf fetched at level 1, 2 or 3 ends the walk with `fault` = 0 and `leaf_level` equal to that level. Levels 1, 2 and 3 mean 16 MB, 256 KB and 4 KB pages. `pa` = ({word[31:8], 12'b0}) + the page offset, which is va[23:0], va[17:0] or va[11:0] for those levels.
- R5: An invalid entry at level L (0 to 3) ends the walk with `fault` = 1 and `fault_code` = L<<8 | 1<<2. For example, level 0 gives 0x004, level 1 gives 0x104 and level 3 gives 0x304.
- R6: A translation error ends the walk with `fault` = 1 and `fault_code` = L<<8 | 4<<2. It is raised by a leaf at level 0, a table pointer at level 3, or a reserved kind at any level. For example, a leaf at level 0 gives 0x010, a reserved kind at level 2 gives 0x210 and a table pointer at level 3 gives 0x310.
- R7: On a successful walk, `entry` is the leaf word with any status update applied and `perm` equals entry[4:2]. `done` is high for exactly one cycle per walk.
- R8: The referenced flag is entry bit 5 and the modified flag is entry bit 6. A leaf is written back to the address it was read from only when bit 5 is clear, or when the access is a store (`req_store` = 1) and bit 6 is clear. The written word has bit 5 set, and also bit 6 set for a store. No write happens in any other case.
- R9: A memory request keeps its valid, address, write flag and write data stable until `mem_req_ready` is seen. A faulting walk issues no write.
- R10: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low for the whole walk, and a `req_valid` raised during a walk starts no second walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| root_ptr | input | 32 | Context table pointer (byte address >> 4) |
| ctx_num | input | 8 | Current context number |
| req_valid | input | 1 | Translate request strobe |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_va | input | 32 | Virtual address to translate |
| req_store | input | 1 | Access is a store |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 36 | Memory byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 10 | Level<<8 \| type<<2 |
| pa | output | 36 | Physical address |
| leaf_level | output | 2 | Level of the leaf (1, 2 or 3), 0 on fault |
| entry | output | 32 | Final entry word |
| perm | output | 3 | Permission code of the leaf |

## Verification
Several properties are checked by assertions on every cycle:
- A stalled memory request stays stable until it is accepted.
- An accepted translate request starts a read.
- `req_ready` stays low while memory traffic is pending.
- `done` lasts a single cycle.
- Every fault code has the legal shape, and every success reports a non-zero leaf level.
- Every write-back sets the referenced flag.

The values themselves can only be shown by the bench's scenarios against page tables it builds: the walk addresses, the physical address sums, the exact fault level and type, and whether a write-back happens at all.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   typedef enum logic [1:0] {
      EK_INVALID = 2'd0,
      EK_TABLE   = 2'd1,
      EK_LEAF    = 2'd2,
      EK_RSVD    = 2'd3
   } ent_kind_e;

   typedef enum logic [1:0] {
      ACT_DESCEND,
      ACT_LEAF,
      ACT_FAULT
   } step_act_e;

   typedef enum logic [1:0] {
      WS_IDLE,
      WS_FETCH,
      WS_WAIT,
      WS_UPDATE
   } walk_state_e;

   localparam logic [2:0] FT_INVALID = 3'd1;
   localparam logic [2:0] FT_XLATE   = 3'd4;
   localparam int         REF_BIT    = 5;
   localparam int         MOD_BIT    = 6;
   localparam int         FCODE_W    = 10;
endpackage

// File: rtl/pgwalk_vaslice.sv
module pgwalk_vaslice #(
   parameter int VA_W = 32,
   parameter int PA_W = 36,
   parameter int L1_W = 8,
   parameter int L2_W = 6,
   parameter int L3_W = 6,
   parameter int PG_W = 12
) (
   input  logic [VA_W-1:0] va,
   input  logic [1:0]      idx_lvl,
   input  logic [1:0]      leaf_lvl,
   output logic [PA_W-1:0] idx_off,
   output logic [PA_W-1:0] page_off
);
   localparam int LO3 = PG_W;
   localparam int LO2 = PG_W + L3_W;
   localparam int LO1 = PG_W + L3_W + L2_W;

   logic [PA_W-1:0] idx_tab [4];
   logic [PA_W-1:0] pg_tab  [4];

   assign idx_tab[0] = '0;
   assign pg_tab[0]  = '0;

   for (genvar g = 1; g <= 3; g++) begin : g_lvl
      localparam int LO = (g == 1) ? LO1 : (g == 2) ? LO2 : LO3;
      localparam int W  = (g == 1) ? L1_W : (g == 2) ? L2_W : L3_W;
      assign idx_tab[g] = PA_W'({va[LO+W-1:LO], 2'b00});
      assign pg_tab[g]  = PA_W'(va[LO-1:0]);
   end

   assign idx_off  = idx_tab[idx_lvl];
   assign page_off = pg_tab[leaf_lvl];
endmodule

// File: rtl/pgwalk_step.sv
module pgwalk_step
   import pgwalk_pkg::*;
#(
   parameter int VA_W = 32,
   parameter int PA_W = 36
) (
   input  logic [VA_W-1:0]    word,
   input  logic [1:0]         lvl,
   input  logic               store,
   output step_act_e          act,
   output logic [FCODE_W-1:0] code,
   output logic [PA_W-1:0]    tbl_base,
   output logic [PA_W-1:0]    page_base,
   output logic               wb_need,
   output logic [VA_W-1:0]    wb_word
);
   ent_kind_e kind;
   logic [2:0] ftype;

   assign kind      = ent_kind_e'(word[1:0]);
   assign tbl_base  = PA_W'({word[VA_W-1:2], 6'b0});
   assign page_base = PA_W'({word[VA_W-1:8], 12'b0});

   always_comb begin
      act   = ACT_FAULT;
      ftype = FT_XLATE;
      unique case (kind)
         EK_INVALID: ftype = FT_INVALID;
         EK_TABLE:   if (lvl != 2'd3) act = ACT_DESCEND;
         EK_LEAF:    if (lvl != 2'd0) act = ACT_LEAF;
         default:    ftype = FT_XLATE;
      endcase
   end

   assign code = {lvl, 3'b000, ftype, 2'b00};

   assign wb_need = !word[REF_BIT] || (store && !word[MOD_BIT]);

   always_comb begin
      wb_word = word;
      wb_word[REF_BIT] = 1'b1;
      if (store) wb_word[MOD_BIT] = 1'b1;
   end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int PA_W  = 36,
   parameter int CTX_W = 8,
   parameter int L1_W  = 8,
   parameter int L2_W  = 6,
   parameter int L3_W  = 6,
   parameter int PG_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VA_W-1:0]    root_ptr,
   input  logic [CTX_W-1:0]   ctx_num,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_va,
   input  logic               req_store,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic               mem_req_write,
   output logic [PA_W-1:0]    mem_req_addr,
   output logic [VA_W-1:0]    mem_req_wdata,
   input  logic               mem_rsp_valid,
   input  logic [VA_W-1:0]    mem_rsp_data,
   output logic               done,
   output logic               fault,
   output logic [FCODE_W-1:0] fault_code,
   output logic [PA_W-1:0]    pa,
   output logic [1:0]         leaf_level,
   output logic [VA_W-1:0]    entry,
   output logic [2:0]         perm
);
   if (L1_W + L2_W + L3_W + PG_W != VA_W) begin : g_bad_split
      $error("pgwalk_top: level widths must sum to VA_W");
   end
   if (PA_W != VA_W + 4) begin : g_bad_pa
      $error("pgwalk_top: PA_W must be VA_W + 4");
   end
   if (CTX_W + 2 > PA_W) begin : g_bad_ctx
      $error("pgwalk_top: CTX_W too wide");
   end

   walk_state_e        st;
   logic [1:0]         lvl;
   logic [PA_W-1:0]    faddr;
   logic [VA_W-1:0]    va_q;
   logic               store_q;
   logic [VA_W-1:0]    wb_q;

   step_act_e          act;
   logic [FCODE_W-1:0] step_code;
   logic [PA_W-1:0]    tbl_base, page_base, idx_off, page_off;
   logic               wb_need;
   logic [VA_W-1:0]    wb_word;
   logic [PA_W-1:0]    root_addr;

   assign root_addr = PA_W'({root_ptr, 4'b0000}) + PA_W'({ctx_num, 2'b00});

   pgwalk_vaslice #(
      .VA_W(VA_W), .PA_W(PA_W), .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W), .PG_W(PG_W)
   ) u_slice (
      .va       (va_q),
      .idx_lvl  (lvl + 2'd1),
      .leaf_lvl (lvl),
      .idx_off  (idx_off),
      .page_off (page_off)
   );

   pgwalk_step #(.VA_W(VA_W), .PA_W(PA_W)) u_step (
      .word      (mem_rsp_data),
      .lvl       (lvl),
      .store     (store_q),
      .act       (act),
      .code      (step_code),
      .tbl_base  (tbl_base),
      .page_base (page_base),
      .wb_need   (wb_need),
      .wb_word   (wb_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= WS_IDLE;
         lvl        <= '0;
         faddr      <= '0;
         va_q       <= '0;
         store_q    <= 1'b0;
         wb_q       <= '0;
         done       <= 1'b0;
         fault      <= 1'b0;
         fault_code <= '0;
         pa         <= '0;
         leaf_level <= '0;
         entry      <= '0;
         perm       <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            WS_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_va;
                  store_q <= req_store;
                  lvl     <= '0;
                  faddr   <= root_addr;
                  st      <= WS_FETCH;
               end
            end
            WS_FETCH: begin
               if (mem_req_ready) st <= WS_WAIT;
            end
            WS_WAIT: begin
               if (mem_rsp_valid) begin
                  unique case (act)
                     ACT_DESCEND: begin
                        lvl   <= lvl + 2'd1;
                        faddr <= tbl_base + idx_off;
                        st    <= WS_FETCH;
                     end
                     ACT_LEAF: begin
                        fault      <= 1'b0;
                        fault_code <= '0;
                        pa         <= page_base + page_off;
                        leaf_level <= lvl;
                        entry      <= wb_word;
                        perm       <= mem_rsp_data[4:2];
                        wb_q       <= wb_word;
                        if (wb_need) begin
                           st <= WS_UPDATE;
                        end else begin
                           done <= 1'b1;
                           st   <= WS_IDLE;
                        end
                     end
                     default: begin
                        fault      <= 1'b1;
                        fault_code <= step_code;
                        pa         <= '0;
                        leaf_level <= '0;
                        entry      <= mem_rsp_data;
                        perm       <= '0;
                        done       <= 1'b1;
                        st         <= WS_IDLE;
                     end
                  endcase
               end
            end
            default: begin
               if (mem_req_ready) begin
                  done <= 1'b1;
                  st   <= WS_IDLE;
               end
            end
         endcase
      end
   end

   assign req_ready     = (st == WS_IDLE);
   assign mem_req_valid = (st == WS_FETCH) || (st == WS_UPDATE);
   assign mem_req_write = (st == WS_UPDATE);
   assign mem_req_addr  = faddr;
   assign mem_req_wdata = wb_q;
endmodule

// File: rtl/pgwalk_checker.sv
module pgwalk_checker #(
   parameter int VA_W = 32,
   parameter int PA_W = 36
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic            mem_req_write,
   input logic [PA_W-1:0] mem_req_addr,
   input logic [VA_W-1:0] mem_req_wdata,
   input logic            done,
   input logic            fault,
   input logic [9:0]      fault_code,
   input logic [1:0]      leaf_level
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)); // R9

   AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> mem_req_valid && !mem_req_write); // R2

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready); // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault |-> fault_code[1:0] == 2'b00 && fault_code[7:5] == 3'b000
      && (fault_code[4:2] == 3'd1 || fault_code[4:2] == 3'd4)); // R5

   AST_LEAF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      done && !fault |-> leaf_level != 2'd0); // R4

   AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> mem_req_wdata[5]); // R8
endmodule

bind pgwalk_top pgwalk_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .mem_req_wdata (mem_req_wdata),
   .done          (done),
   .fault         (fault),
   .fault_code    (fault_code),
   .leaf_level    (leaf_level)
);

// File: tb/tb_pgwalk_top.sv
`timescale 1ns/1ps
module tb_pgwalk_top;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [31:0] root_ptr = 32'h0000_1000;
   logic [7:0]  ctx_num = 8'd3;
   logic        req_valid = 0;
   logic        req_ready;
   logic [31:0] req_va = 0;
   logic        req_store = 0;
   logic        mem_req_valid, mem_req_ready, mem_req_write;
   logic [35:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        done, fault;
   logic [9:0]  fault_code;
   logic [35:0] pa;
   logic [1:0]  leaf_level;
   logic [31:0] entry;
   logic [2:0]  perm;

   always #2 clk = ~clk;

   pgwalk_top dut (.*);

   logic [31:0] mem [logic [35:0]];
   int n_rd, n_wr, n_done, errors, checks, tick;
   logic [35:0] first_rd, wr_addr, pend_addr;
   logic [31:0] wr_data;
   logic pend, stall, saw_busy, finished;
   logic        c_fault;
   logic [9:0]  c_code;
   logic [35:0] c_pa;
   logic [1:0]  c_lvl;
   logic [31:0] c_entry;
   logic [2:0]  c_perm;

   localparam logic [35:0] CTX_SLOT = 36'h1000C;
   localparam logic [35:0] T1 = 36'h20000, T2 = 36'h30000, T3 = 36'h40000;

   function automatic logic [31:0] rd(input logic [35:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction
   function automatic logic [31:0] ptd(input logic [35:0] t);
      return {t[35:6], 2'b01};
   endfunction
   function automatic logic [31:0] leafw(input logic [35:0] p, input logic [2:0] pm,
                                         input logic r, input logic m);
      return {p[35:12], 1'b0, m, r, pm, 2'b10};
   endfunction
   function automatic logic [35:0] a1(input logic [31:0] va);
      return T1 + {va[31:24], 2'b00};
   endfunction
   function automatic logic [35:0] a2(input logic [31:0] va);
      return T2 + {va[23:18], 2'b00};
   endfunction
   function automatic logic [35:0] a3(input logic [31:0] va);
      return T3 + {va[17:12], 2'b00};
   endfunction

   // memory model and monitor
   initial begin
      mem_rsp_valid = 0; mem_rsp_data = 0; mem_req_ready = 1; pend = 0;
      tick = 0; stall = 0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 0;
         mem_rsp_data  = 0;
         if (pend) begin
            mem_rsp_valid = 1; mem_rsp_data = rd(pend_addr); pend = 0;
         end
         mem_req_ready = stall ? (tick % 3 == 2) : 1'b1;
         tick++;
         if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
               mem[mem_req_addr] = mem_req_wdata;
               n_wr++; wr_addr = mem_req_addr; wr_data = mem_req_wdata;
            end else begin
               if (n_rd == 0) first_rd = mem_req_addr;
               n_rd++; pend = 1; pend_addr = mem_req_addr;
            end
         end
         if (rst_n && done) begin
            n_done++; c_fault = fault; c_code = fault_code; c_pa = pa;
            c_lvl = leaf_level; c_entry = entry; c_perm = perm;
         end
         if (rst_n && !req_ready) saw_busy = 1;
      end
   end

   task automatic chk(input logic ok, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   task automatic start(input logic [31:0] va, input logic st);
      int lim = 0;
      @(posedge clk); #1;
      while (!req_ready && lim < 200) begin @(posedge clk); #1; lim++; end
      n_rd = 0; n_wr = 0; n_done = 0; saw_busy = 0;
      req_valid = 1; req_va = va; req_store = st;
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic finish_wait();
      int lim = 0;
      while (n_done == 0 && lim < 300) begin @(posedge clk); #1; lim++; end
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic walk(input logic [31:0] va, input logic st);
      start(va, st);
      finish_wait();
   endtask

   task automatic expect_leaf(input string tag, input logic [31:0] va,
                              input logic [31:0] w, input logic [1:0] lv,
                              input logic [35:0] off, input logic st, input int reads);
      logic [31:0] upd;
      logic        need;
      upd = w | 32'h20 | (st ? 32'h40 : 32'h0);
      need = !w[5] || (st && !w[6]);
      chk(n_done == 1, {tag, " R7 done count"}, n_done, 1);
      chk(!c_fault, {tag, " R4 no fault"}, c_fault, 0);
      chk(c_lvl == lv, {tag, " R4 level"}, c_lvl, lv);
      chk(c_pa == {w[31:8], 12'h000} + off, {tag, " R4 pa"}, c_pa, {w[31:8], 12'h000} + off);
      chk(c_entry == upd, {tag, " R7 entry"}, c_entry, upd);
      chk(c_perm == w[4:2], {tag, " R7 perm"}, c_perm, w[4:2]);
      chk(n_rd == reads, {tag, " R3 reads"}, n_rd, reads);
      chk(first_rd == CTX_SLOT, {tag, " R2 first fetch"}, first_rd, CTX_SLOT);
      chk(n_wr == (need ? 1 : 0), {tag, " R8 write count"}, n_wr, need);
      if (need) begin
         chk(wr_data == upd, {tag, " R8 write data"}, wr_data, upd);
      end
      chk(saw_busy, {tag, " R10 busy seen"}, saw_busy, 1);
   endtask

   task automatic expect_fault(input string tag, input logic [9:0] code, input int reads);
      chk(n_done == 1, {tag, " R7 done count"}, n_done, 1);
      chk(c_fault, {tag, " fault flag"}, c_fault, 1);
      chk(c_code == code, {tag, " fault code"}, c_code, code);
      chk(n_rd == reads, {tag, " R3 reads"}, n_rd, reads);
      chk(n_wr == 0, {tag, " R9 no write on fault"}, n_wr, 0);
   endtask

   task automatic build_tables();
      mem.delete();
      mem[CTX_SLOT] = ptd(T1);
      mem[36'h20048] = ptd(T2);
      mem[36'h30034] = ptd(T3);
   endtask

   task automatic t_reset();
      chk(req_ready == 1, "R1 req_ready", req_ready, 1);
      chk(mem_req_valid == 0, "R1 mem_req_valid", mem_req_valid, 0);
      chk(done == 0, "R1 done", done, 0);
   endtask

   task automatic t_l3_leaf();
      logic [31:0] va = 32'h1234_5678;
      logic [31:0] w  = leafw(36'h9_ABCD_E000, 3'd3, 0, 0);
      mem[a3(va)] = w;
      walk(va, 0);
      expect_leaf("L3 load", va, w, 2'd3, {24'h0, va[11:0]}, 0, 4);
      chk(wr_addr == a3(va), "R8 write address", wr_addr, a3(va));
      w = rd(a3(va));
      walk(va, 0);
      expect_leaf("L3 reload", va, w, 2'd3, {24'h0, va[11:0]}, 0, 4);
      walk(va, 1);
      expect_leaf("L3 store", va, w, 2'd3, {24'h0, va[11:0]}, 1, 4);
      w = rd(a3(va));
      chk(w[6] && w[5], "R8 store sets both flags", w[6:5], 2'b11);
      walk(va, 1);
      expect_leaf("L3 store again", va, w, 2'd3, {24'h0, va[11:0]}, 1, 4);
   endtask

   task automatic t_big_pages();
      logic [31:0] vb = 32'h128C_1234;
      logic [31:0] wb = leafw(36'h5_0000_0000, 3'd5, 1, 1);
      logic [31:0] vc = 32'h7FAB_CDEF;
      logic [31:0] wc = leafw(36'h2_0000_1000, 3'd6, 0, 1);
      mem[a2(vb)] = wb;
      walk(vb, 0);
      expect_leaf("L2 leaf", vb, wb, 2'd2, {18'h0, vb[17:0]}, 0, 3);
      mem[a1(vc)] = wc;
      walk(vc, 0);
      expect_leaf("L1 leaf", vc, wc, 2'd1, {12'h0, vc[23:0]}, 0, 2);
   endtask

   task automatic t_faults();
      mem[CTX_SLOT] = 32'h0;
      walk(32'h1234_5678, 0);
      expect_fault("R5 ctx invalid", 10'h004, 1);
      mem[CTX_SLOT] = leafw(36'h1000, 3'd0, 1, 1);
      walk(32'h1234_5678, 0);
      expect_fault("R6 ctx leaf", 10'h010, 1);
      mem[CTX_SLOT] = ptd(T1);
      walk(32'h5500_0000, 0);
      expect_fault("R5 L1 invalid", 10'h104, 2);
      mem[a2(32'h12C0_0000)] = 32'h3;
      walk(32'h12C0_0000, 0);
      expect_fault("R6 L2 reserved", 10'h210, 3);
      walk(32'h1234_7000, 0);
      expect_fault("R5 L3 invalid", 10'h304, 4);
      mem[a3(32'h1234_8000)] = ptd(36'h50000);
      walk(32'h1234_8000, 0);
      expect_fault("R6 L3 pointer", 10'h310, 4);
   endtask

   task automatic t_stall();
      logic [31:0] vb = 32'h128C_1234;
      stall = 1;
      walk(vb, 0);
      expect_leaf("R9 stalled L2", vb, rd(a2(vb)), 2'd2, {18'h0, vb[17:0]}, 0, 3);
      stall = 0;
   endtask

   task automatic t_busy();
      logic [31:0] vb = 32'h128C_1234;
      start(vb, 0);
      req_valid = 1; req_va = 32'h5500_0000;
      repeat (3) @(posedge clk);
      #1 req_valid = 0;
      finish_wait();
      repeat (10) @(posedge clk);
      #1;
      chk(n_done == 1, "R10 single walk", n_done, 1);
      chk(n_rd == 3, "R10 no extra reads", n_rd, 3);
      chk(!c_fault && c_pa == {rd(a2(vb))[31:8], 12'h0} + vb[17:0], "R10 first walk result",
          c_pa, {rd(a2(vb))[31:8], 12'h0} + vb[17:0]);
   endtask

   initial begin
      errors = 0; checks = 0; finished = 0;
      n_rd = 0; n_wr = 0; n_done = 0; saw_busy = 0;
      build_tables();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_l3_leaf();
      t_big_pages();
      t_faults();
      t_stall();
      t_busy();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule